// File: doc/BRIEF.md
# PLL Frequency Readback Calculator

This block turns snapshots of clock-generator settings into an output frequency in kHz. For the requested clock domain it decodes the source-select field, picks the PLL that feeds that domain, and extracts the feedback multipliers, the reference dividers and the post-divider shift. It then evaluates the frequency against a fixed 27000 kHz reference. Two PLL layouts are understood. The single-stage layout packs every field into one control word. The two-stage layout keeps a cascaded multiplier pair in a separate coefficient word, and its second stage can be bypassed.

A request is one cycle of `start_i`, with the domain selector and all setting words valid in that cycle. The words are captured at once, so they may change afterwards. Multiplication by the 8-bit factors is done in one step, and each division runs through a shared restoring divider that produces one quotient bit per cycle. When the result has been shifted by the post-divider, `khz_o` is updated and `done_o` is high for one cycle. Configurations that are known to give zero skip the arithmetic.

Top module: `pll_freq_calc`

## Requirements
- R1: While `rst_ni` is low and after it is released, `khz_o` is 0 and `done_o` is 0 until the first request completes.
- R2: Single-stage layout: control bits 18:16 hold shift P, bits 15:8 hold N, bits 7:0 hold M. The result is floor(27000*N/M) shifted right by P.
- R3: If control bit 31 (enable) is clear, the result is 0 in both layouts.
- R4: Two-stage layout: coefficient bits 31:24 hold N2, bits 23:16 hold M2, bits 15:8 hold N1 and bits 7:0 hold M1. P is in control bits 18:16. The first stage is floor(27000*N1/M1). An M1 of 0, or an M of 0 in the single-stage layout, gives 0.
- R5: The second stage, floor(stage1*N2/M2), is applied only when control bit 30 is set and control bit 8 is clear. Otherwise stage1 goes straight to the shift.
- R6: With the second stage active, an M2 of 0 forces the result to 0.
- R7: A source-select value of 3 uses the two-stage core PLL words and a value of 2 uses the single-stage auxiliary PLL control word. Values 0 and 1 give 0. The core domain reads select bits 1:0 of `mast_sel_i` and the shader domain reads bits 5:4.
- R8: `dom_sel_i` encodes 0 as core, 1 as shader and 2 as memory. Memory always uses the two-stage memory PLL words. The value 3 gives 0.
- R9: Each stage is truncated by integer division before the next stage. Factors up to 255 at both stages give exact results with no overflow.
- R10: `done_o` is high for exactly one cycle per completed request. `khz_o` changes only in that cycle and holds its value until the next one.
- R11: A `start_i` that arrives while a request is in progress is ignored. Input changes after the accepted start do not affect the result.
- R12: A request whose result is 0 by R3, R4, R6, R7 or R8 raises `done_o` two cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; inputs are sampled in the same cycle |
| dom_sel_i | input | 2 | Domain: 0 core, 1 shader, 2 memory, 3 none |
| mast_sel_i | input | 32 | Master source-select word |
| core_pll_ctrl_i | input | 32 | Two-stage core PLL control word |
| core_pll_coef_i | input | 32 | Two-stage core PLL coefficient word |
| aux_pll_ctrl_i | input | 32 | Single-stage auxiliary PLL control word |
| mem_pll_ctrl_i | input | 32 | Two-stage memory PLL control word |
| mem_pll_coef_i | input | 32 | Two-stage memory PLL coefficient word |
| khz_o | output | 32 | Computed frequency in kHz |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong captured configuration shows up as a wrong `khz_o` value at the next `done_o`, roughly forty or eighty cycles after the start. A divider that loses a quotient bit or takes a wrong step count shows up in the truncated values and in the largest-factor case. A sequencer that accepts a second strobe or takes a wrong turn at the bypass decision shows up as an extra or early `done_o`, or as a zero result that arrives later than two cycles. Mid-request input changes and pulses are applied so that any leak of live inputs into the result is visible at the ports.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int FW = 8;   // multiplier / divider field width
  localparam int PW = 3;   // post-divider shift width

  typedef struct packed {
    logic [FW-1:0] n1;
    logic [FW-1:0] m1;
    logic [FW-1:0] n2;
    logic [FW-1:0] m2;
    logic [PW-1:0] p;
    logic          stage2;
    logic          zero;
  } pll_cfg_t;

  function automatic pll_cfg_t decode_single(input logic [31:0] ctrl);
    pll_cfg_t c;
    c.n1     = ctrl[15:8];
    c.m1     = ctrl[7:0];
    c.n2     = '0;
    c.m2     = '0;
    c.p      = ctrl[18:16];
    c.stage2 = 1'b0;
    c.zero   = !ctrl[31] || (ctrl[7:0] == '0);
    return c;
  endfunction

  function automatic pll_cfg_t decode_dual(input logic [31:0] ctrl, input logic [31:0] coef);
    pll_cfg_t c;
    c.n2     = coef[31:24];
    c.m2     = coef[23:16];
    c.n1     = coef[15:8];
    c.m1     = coef[7:0];
    c.p      = ctrl[18:16];
    c.stage2 = ctrl[30] && !ctrl[8];
    c.zero   = !ctrl[31] || (coef[7:0] == '0) || (c.stage2 && coef[23:16] == '0);
    return c;
  endfunction

  function automatic pll_cfg_t cfg_zero();
    pll_cfg_t c;
    c      = '0;
    c.zero = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/pll_src_decode.sv
module pll_src_decode
  import pll_calc_pkg::*;
(
  input  logic [1:0]  dom_sel_i,
  input  logic [31:0] mast_sel_i,
  input  logic [31:0] core_pll_ctrl_i,
  input  logic [31:0] core_pll_coef_i,
  input  logic [31:0] aux_pll_ctrl_i,
  input  logic [31:0] mem_pll_ctrl_i,
  input  logic [31:0] mem_pll_coef_i,
  output pll_cfg_t    cfg_o
);
  logic [1:0] src;

  always_comb begin
    src = (dom_sel_i == 2'd1) ? mast_sel_i[5:4] : mast_sel_i[1:0];
    unique case (dom_sel_i)
      2'd0, 2'd1: begin
        unique case (src)
          2'd3:    cfg_o = decode_dual(core_pll_ctrl_i, core_pll_coef_i);
          2'd2:    cfg_o = decode_single(aux_pll_ctrl_i);
          default: cfg_o = cfg_zero();
        endcase
      end
      2'd2:    cfg_o = decode_dual(mem_pll_ctrl_i, mem_pll_coef_i);
      default: cfg_o = cfg_zero();
    endcase
  end
endmodule

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int DW = 40,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [DW-1:0] quot_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] q_q;
  logic [VW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [VW:0]   trial, diff, rem_nxt;
  logic          fits;

  always_comb begin
    trial   = {rem_q, q_q[DW-1]};
    fits    = trial >= {1'b0, den_q};
    diff    = trial - {1'b0, den_q};
    rem_nxt = fits ? diff : trial;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= dividend_i;
        rem_q <= '0;
        den_q <= divisor_i;
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        q_q   <= {q_q[DW-2:0], fits};
        rem_q <= rem_nxt[VW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign quot_o = q_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int REF_KHZ = 27000,
  parameter int ACC_W   = 40,
  parameter int OUT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       dom_sel_i,
  input  logic [31:0]      mast_sel_i,
  input  logic [31:0]      core_pll_ctrl_i,
  input  logic [31:0]      core_pll_coef_i,
  input  logic [31:0]      aux_pll_ctrl_i,
  input  logic [31:0]      mem_pll_ctrl_i,
  input  logic [31:0]      mem_pll_coef_i,
  output logic [OUT_W-1:0] khz_o,
  output logic             done_o
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DIV1 = 2'd1, S_DIV2 = 2'd2, S_FIN = 2'd3} state_e;

  state_e          state_q;
  pll_cfg_t        cfg_d, cfg_q;
  logic [ACC_W-1:0] acc_q, div_quot;
  logic [FW-1:0]   den_q;
  logic            go_q, div_done, done_q;
  logic [OUT_W-1:0] khz_q;

  pll_src_decode u_dec (
    .dom_sel_i       (dom_sel_i),
    .mast_sel_i      (mast_sel_i),
    .core_pll_ctrl_i (core_pll_ctrl_i),
    .core_pll_coef_i (core_pll_coef_i),
    .aux_pll_ctrl_i  (aux_pll_ctrl_i),
    .mem_pll_ctrl_i  (mem_pll_ctrl_i),
    .mem_pll_coef_i  (mem_pll_coef_i),
    .cfg_o           (cfg_d)
  );

  pll_div_seq #(.DW(ACC_W), .VW(FW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go_q),
    .dividend_i (acc_q),
    .divisor_i  (den_q),
    .quot_o     (div_quot),
    .done_o     (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      acc_q   <= '0;
      den_q   <= '0;
      go_q    <= 1'b0;
      khz_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cfg_q <= cfg_d;
          if (cfg_d.zero) begin
            acc_q   <= '0;
            state_q <= S_FIN;
          end else begin
            acc_q   <= ACC_W'(REF_KHZ) * ACC_W'(cfg_d.n1);
            den_q   <= cfg_d.m1;
            go_q    <= 1'b1;
            state_q <= S_DIV1;
          end
        end
        S_DIV1: if (div_done) begin
          if (cfg_q.stage2) begin
            acc_q   <= ACC_W'(div_quot[OUT_W-1:0]) * ACC_W'(cfg_q.n2);
            den_q   <= cfg_q.m2;
            go_q    <= 1'b1;
            state_q <= S_DIV2;
          end else begin
            acc_q   <= div_quot;
            state_q <= S_FIN;
          end
        end
        S_DIV2: if (div_done) begin
          acc_q   <= div_quot;
          state_q <= S_FIN;
        end
        S_FIN: begin
          khz_q   <= OUT_W'(acc_q >> cfg_q.p);
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign khz_o  = khz_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [OUT_W-1:0] khz_o,
  input logic [1:0]       state_i,
  input logic             zero_i,
  input logic             div_done_i,
  input logic [ACC_W-1:0] quot_i
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_KHZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(khz_o)); // R10

  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0 && start_i && zero_i) |=> ##1 (done_o && khz_o == '0)); // R12

  AST_DIV_IN_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done_i |-> (state_i == 2'd1 || state_i == 2'd2)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done_i |-> (quot_i[ACC_W-1:OUT_W] == '0)); // R9
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .khz_o      (khz_o),
  .state_i    (state_q),
  .zero_i     (cfg_d.zero),
  .div_done_i (div_done),
  .quot_i     (div_quot)
);

// File: tb/tb_pll_freq_calc.sv
module tb_pll_freq_calc;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  dom = '0;
  logic [31:0] mast = '0, a_ctrl = '0, a_coef = '0, b_ctrl = '0, m_ctrl = '0, m_coef = '0;
  logic [31:0] khz;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_freq_calc dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dom_sel_i(dom), .mast_sel_i(mast),
    .core_pll_ctrl_i(a_ctrl), .core_pll_coef_i(a_coef), .aux_pll_ctrl_i(b_ctrl),
    .mem_pll_ctrl_i(m_ctrl), .mem_pll_coef_i(m_coef), .khz_o(khz), .done_o(done)
  );

  typedef struct packed {
    logic [1:0]  dom;
    logic [31:0] mast, a_ctrl, a_coef, b_ctrl, m_ctrl, m_coef, exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h3,  32'h8001_0100, 32'h0302_0A01, 32'h0, 32'h0, 32'h0, 32'd135000, 8'd5},   // R5 bit8 bypass
    '{2'd0, 32'h3,  32'hC002_0000, 32'h0302_1403, 32'h0, 32'h0, 32'h0, 32'd67500, 8'd4},    // R4 two stage
    '{2'd1, 32'h20, 32'h0, 32'h0, 32'h8003_1E04, 32'h0, 32'h0, 32'd25312, 8'd2},            // R2 single
    '{2'd1, 32'h30, 32'hC002_0000, 32'h0302_1403, 32'h0, 32'h0, 32'h0, 32'd67500, 8'd7},    // R7 shader bits
    '{2'd0, 32'h31, 32'hC002_0000, 32'h0302_1403, 32'h0, 32'h0, 32'h0, 32'd0, 8'd7},        // R7 select 1
    '{2'd2, 32'h0,  32'h0, 32'h0, 32'h0, 32'hC000_0000, 32'h0504_0702, 32'd118125, 8'd8},   // R8 memory
    '{2'd2, 32'h0,  32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0504_0702, 32'd94500, 8'd5},    // R5 bit30 clear
    '{2'd0, 32'h3,  32'h4000_0000, 32'h0302_1403, 32'h0, 32'h0, 32'h0, 32'd0, 8'd3},        // R3 disabled
    '{2'd0, 32'h3,  32'hC000_0000, 32'h0302_1400, 32'h0, 32'h0, 32'h0, 32'd0, 8'd4},        // R4 M1 zero
    '{2'd0, 32'h3,  32'hC000_0000, 32'h0300_1403, 32'h0, 32'h0, 32'h0, 32'd0, 8'd6},        // R6 M2 zero
    '{2'd0, 32'h3,  32'hC000_0100, 32'h0300_1403, 32'h0, 32'h0, 32'h0, 32'd180000, 8'd6},   // R6 bypassed
    '{2'd0, 32'h2,  32'h0, 32'h0, 32'h8000_0107, 32'h0, 32'h0, 32'd3857, 8'd9},             // R9 truncation
    '{2'd2, 32'h0,  32'h0, 32'h0, 32'h0, 32'hC000_0000, 32'hFF01_FF01, 32'd1755675000, 8'd9}, // R9 max
    '{2'd3, 32'h3,  32'hC000_0000, 32'h0302_1403, 32'h0, 32'h0, 32'h0, 32'd0, 8'd8},        // R8 none
    '{2'd0, 32'h2,  32'h0, 32'h0, 32'h8000_0A00, 32'h0, 32'h0, 32'd0, 8'd4},                // R4 single M zero
    '{2'd0, 32'h2,  32'h0, 32'h0, 32'h8007_FF01, 32'h0, 32'h0, 32'd53789, 8'd2}             // R2 shift 7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    dom = v.dom; mast = v.mast; a_ctrl = v.a_ctrl; a_coef = v.a_coef;
    b_ctrl = v.b_ctrl; m_ctrl = v.m_ctrl; m_coef = v.m_coef;
  endtask

  // drive at negedge, pulse start, count negedges until done
  task automatic run(input vec_t v, output int cyc);
    @(negedge clk);
    load(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cyc;
    int quiet;
    vec_t v;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", khz, 32'd0);
    check("R1", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", khz, 32'd0);
    check("R1", {31'd0, done}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], cyc);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), khz, VECS[i].exp);
      @(negedge clk);
      check("R10 done single cycle", {31'd0, done}, 32'd0);
      check("R10 hold", khz, VECS[i].exp);
      if (VECS[i].exp == 0) check("R12 zero latency", cyc, 32'd2);
    end

    // R11: second start while busy, inputs changed mid-request
    @(negedge clk);
    load(VECS[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    v = VECS[13];
    load(v);
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    load(VECS[12]);
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check("R11 result from accepted start", khz, 32'd67500);
    quiet = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (done) quiet++;
    end
    check("R11 no extra completion", quiet, 32'd0);
    check("R10 hold after idle", khz, 32'd67500);

    finish_run();
  end
endmodule